// File: doc/BRIEF.md
# I2C Bus Condition Monitor

This block watches the two lines of an I2C bus and finds the START and STOP conditions on them. Each line passes through a small synchronizer before it is judged. From the conditions it keeps a level that says the bus is in use, and it raises two sticky flags for the control logic around it. One flag reports a STOP that ended a transfer this node took part in. The other reports a START or STOP that arrived in the middle of a byte while this node was involved.

The surrounding controller supplies the context the monitor cannot see on the wires. It says whether this node is the master of the current transfer, it strobes when this node's slave address was matched, and it marks the slave address phase. Each flag has its own clear strobe. A low enable clears every output and holds the monitor idle. Clock generation, data shifting and address comparison live elsewhere.

Top module: `i2c_bus_monitor`

## Requirements
- R1: After reset, `bus_busy`, `stop_flag` and `bus_err` are all 0.
- R2: A START is SDA falling while SCL stays high, judged on samples taken after a two-stage synchronizer. It sets `bus_busy` on the third rising clock edge after the raw SDA change.
- R3: A STOP is SDA rising while SCL stays high, judged the same way. It clears `bus_busy` with the same latency.
- R4: While `enable` is 0, all three outputs are 0 from the next edge on, and bus conditions seen in that time set nothing.
- R5: A STOP seen while `own_master` is 1 sets `stop_flag`.
- R6: A STOP sets `stop_flag` when `slave_hit` was pulsed after the most recent START or STOP. A hit that is followed by a repeated START no longer counts.
- R7: A STOP with `own_master` at 0 and no slave hit in the current transfer leaves `stop_flag` at 0.
- R8: A START or STOP is misplaced when SCL has risen since the last completed bit and between 1 and 8 bits of the current 9-bit frame (8 data bits plus acknowledge) are complete. A misplaced condition sets `bus_err` when this node is involved, meaning `own_master` is 1 or there was a slave hit in this transfer.
- R9: A misplaced condition seen while `addr_phase` is 1 does not set `bus_err`.
- R10: A condition at a frame boundary (0 bits complete) never sets `bus_err`, and neither does a misplaced condition when this node is not involved.
- R11: `stop_clr` clears `stop_flag` and `err_clr` clears `bus_err`. If a set and a clear land on the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_in | input | 1 | Raw SCL line sample |
| sda_in | input | 1 | Raw SDA line sample |
| enable | input | 1 | Monitor enable; when low, the monitor is cleared and held idle |
| own_master | input | 1 | This node is master of the current transfer |
| slave_hit | input | 1 | Strobe: this node's slave address was matched |
| addr_phase | input | 1 | The slave address phase is in progress |
| stop_clr | input | 1 | Clears `stop_flag` |
| err_clr | input | 1 | Clears `bus_err` |
| bus_busy | output | 1 | The bus is between a START and a STOP |
| stop_flag | output | 1 | Sticky flag: a STOP ended a transfer this node took part in |
| bus_err | output | 1 | Sticky flag: a misplaced START or STOP was seen |

## Verification
The hardest state to reach is a misplaced condition. To get there, SCL must have risen inside a partly sent frame, and SDA must then move while SCL stays high. The stimulus builds exactly that case. It clocks a few complete bits, then lowers SCL, sets SDA, raises SCL and toggles SDA before any falling edge. The same sequence is then repeated under each qualifier: with the address phase asserted, with the node not involved, and at a frame boundary. A behavioural model is compared against the outputs on every clock, so the exact cycle in which each flag sets and clears is checked as well.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;

  typedef struct packed {
    logic scl;
    logic sda;
  } line_t;

  // SDA falls while SCL is high in both samples
  function automatic logic is_start(line_t now, line_t was);
    return now.scl && was.scl && was.sda && !now.sda;
  endfunction

  // SDA rises while SCL is high in both samples
  function automatic logic is_stop(line_t now, line_t was);
    return now.scl && was.scl && !was.sda && now.sda;
  endfunction

  // a bit is on the wire and the frame has started but has not finished
  function automatic logic mid_frame(logic risen, int unsigned done, int unsigned frame);
    return risen && (done != 0) && (done < frame);
  endfunction

endpackage

// File: rtl/i2c_mon_sync.sv
module i2c_mon_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage[0] <= '1;
          else        stage[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage[i] <= '1;
          else        stage[i] <= stage[i-1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/i2c_mon_cond.sv
module i2c_mon_cond
  import i2c_mon_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  line_t now,
  output logic  start_evt,
  output logic  stop_evt,
  output logic  scl_rise,
  output logic  scl_fall
);
  line_t was;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) was <= '1;
    else        was <= now;

  assign start_evt = is_start(now, was);
  assign stop_evt  = is_stop(now, was);
  assign scl_rise  = now.scl && !was.scl;
  assign scl_fall  = !now.scl && was.scl;

  AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_evt && stop_evt)); // R2
endmodule

// File: rtl/i2c_mon_bitpos.sv
module i2c_mon_bitpos
  import i2c_mon_pkg::*;
#(
  parameter int FRAME_BITS = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic start_evt,
  input  logic stop_evt,
  input  logic scl_rise,
  input  logic scl_fall,
  output logic misplaced
);
  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

  logic [CNT_W-1:0] done_q;
  logic             risen_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      done_q  <= '0;
      risen_q <= 1'b0;
    end else if (!enable || start_evt || stop_evt) begin
      done_q  <= '0;
      risen_q <= 1'b0;
    end else if (scl_rise) begin
      risen_q <= 1'b1;
    end else if (scl_fall && risen_q) begin
      risen_q <= 1'b0;
      done_q  <= (done_q == LAST) ? '0 : done_q + 1'b1;
    end

  assign misplaced = mid_frame(risen_q, 32'(done_q), FRAME_BITS);

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(done_q) < FRAME_BITS); // R8
  AST_FRESH_AFTER_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt || stop_evt) |=> !misplaced); // R10
endmodule

// File: rtl/i2c_mon_flags.sv
module i2c_mon_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic start_evt,
  input  logic stop_evt,
  input  logic misplaced,
  input  logic own_master,
  input  logic slave_hit,
  input  logic addr_phase,
  input  logic stop_clr,
  input  logic err_clr,
  output logic bus_busy,
  output logic stop_flag,
  output logic bus_err
);
  logic hit_q;
  logic involved;
  logic stop_set;
  logic err_set;

  assign involved = own_master || hit_q;
  assign stop_set = stop_evt && involved;
  assign err_set  = (start_evt || stop_evt) && misplaced && involved && !addr_phase;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                      hit_q <= 1'b0;
    else if (!enable)                hit_q <= 1'b0;
    else if (start_evt || stop_evt)  hit_q <= 1'b0;
    else if (slave_hit)              hit_q <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          bus_busy <= 1'b0;
    else if (!enable)    bus_busy <= 1'b0;
    else if (start_evt)  bus_busy <= 1'b1;
    else if (stop_evt)   bus_busy <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          stop_flag <= 1'b0;
    else if (!enable)    stop_flag <= 1'b0;
    else if (stop_set)   stop_flag <= 1'b1;
    else if (stop_clr)   stop_flag <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          bus_err <= 1'b0;
    else if (!enable)    bus_err <= 1'b0;
    else if (err_set)    bus_err <= 1'b1;
    else if (err_clr)    bus_err <= 1'b0;

  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && start_evt) |=> bus_busy); // R2
  AST_BUSY_OFF_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !bus_busy); // R3
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!bus_busy && !stop_flag && !bus_err)); // R4
  AST_STOPF_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_flag) |-> $past(stop_evt)); // R5
  AST_ERR_NOT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_err) |-> (!$past(addr_phase) && $past(misplaced))); // R9
endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
  import i2c_mon_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FRAME_BITS  = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic enable,
  input  logic own_master,
  input  logic slave_hit,
  input  logic addr_phase,
  input  logic stop_clr,
  input  logic err_clr,
  output logic bus_busy,
  output logic stop_flag,
  output logic bus_err
);
  line_t raw_line;
  line_t sync_line;
  logic  start_evt;
  logic  stop_evt;
  logic  scl_rise;
  logic  scl_fall;
  logic  misplaced;

  assign raw_line = '{scl: scl_in, sda: sda_in};

  i2c_mon_sync #(.WIDTH($bits(line_t)), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_line), .q(sync_line)
  );

  i2c_mon_cond u_cond (
    .clk(clk), .rst_n(rst_n), .now(sync_line),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  i2c_mon_bitpos #(.FRAME_BITS(FRAME_BITS)) u_bitpos (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .misplaced(misplaced)
  );

  i2c_mon_flags u_flags (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .start_evt(start_evt), .stop_evt(stop_evt), .misplaced(misplaced),
    .own_master(own_master), .slave_hit(slave_hit), .addr_phase(addr_phase),
    .stop_clr(stop_clr), .err_clr(err_clr),
    .bus_busy(bus_busy), .stop_flag(stop_flag), .bus_err(bus_err)
  );
endmodule

// File: tb/i2c_bus_monitor_tb_top.sv
module i2c_bus_monitor_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_in = 1'b1, sda_in = 1'b1, enable = 1'b0, own_master = 1'b0;
  logic slave_hit = 1'b0, addr_phase = 1'b0, stop_clr = 1'b0, err_clr = 1'b0;
  logic bus_busy, stop_flag, bus_err;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  bit saw_stopf = 0;

  always #4 clk = ~clk; // 125 MHz

  i2c_bus_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in), .enable(enable),
    .own_master(own_master), .slave_hit(slave_hit), .addr_phase(addr_phase),
    .stop_clr(stop_clr), .err_clr(err_clr),
    .bus_busy(bus_busy), .stop_flag(stop_flag), .bus_err(bus_err)
  );

  // reference model: index 0 = first sync stage, 1 = second, 2 = previous sample
  bit q_scl[$] = '{1, 1, 1};
  bit q_sda[$] = '{1, 1, 1};
  bit m_busy, m_stopf, m_err, m_hit, m_risen;
  int m_done;

  always @(posedge clk or negedge rst_n) begin
    bit st, sp, rs, fl, inv, odd;
    if (!rst_n) begin
      q_scl = '{1, 1, 1}; q_sda = '{1, 1, 1};
      m_busy = 0; m_stopf = 0; m_err = 0; m_hit = 0; m_risen = 0; m_done = 0;
    end else begin
      st  = q_scl[1] && q_scl[2] && q_sda[2] && !q_sda[1];
      sp  = q_scl[1] && q_scl[2] && !q_sda[2] && q_sda[1];
      rs  = q_scl[1] && !q_scl[2];
      fl  = !q_scl[1] && q_scl[2];
      inv = own_master || m_hit;
      odd = m_risen && m_done >= 1 && m_done <= 8;
      if (!enable) begin
        m_busy = 0; m_stopf = 0; m_err = 0; m_hit = 0; m_risen = 0; m_done = 0;
      end else begin
        if (st) m_busy = 1;
        if (sp) m_busy = 0;
        if (sp && inv) m_stopf = 1; else if (stop_clr) m_stopf = 0;
        if ((st || sp) && odd && inv && !addr_phase) m_err = 1; else if (err_clr) m_err = 0;
        if (st || sp) begin m_hit = 0; m_risen = 0; m_done = 0; end
        else begin
          if (slave_hit) m_hit = 1;
          if (rs) m_risen = 1;
          else if (fl && m_risen) begin m_risen = 0; m_done = (m_done + 1) % 9; end
        end
      end
      q_scl.push_front(scl_in); void'(q_scl.pop_back());
      q_sda.push_front(sda_in); void'(q_sda.pop_back());
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    if (stop_flag) saw_stopf = 1;
    checks += 3;
    if (bus_busy !== m_busy) begin errors++;
      $display("FAIL R2/R3 busy: actual=%0b expected=%0b t=%0t", bus_busy, m_busy, $time); end
    if (stop_flag !== m_stopf) begin errors++;
      $display("FAIL R5 stop_flag: actual=%0b expected=%0b t=%0t", stop_flag, m_stopf, $time); end
    if (bus_err !== m_err) begin errors++;
      $display("FAIL R8 bus_err: actual=%0b expected=%0b t=%0t", bus_err, m_err, $time); end
  end

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic send_bit(logic b);
    scl_in = 0; step(2); sda_in = b; step(2);
    scl_in = 1; step(4); scl_in = 0; step(2);
  endtask

  task automatic send_frame(logic [7:0] d, logic ack);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    send_bit(ack);
  endtask

  task automatic do_start();
    if (!scl_in) begin sda_in = 1; step(2); scl_in = 1; end
    step(4); sda_in = 0; step(4); scl_in = 0; step(2);
  endtask

  task automatic do_stop();
    scl_in = 0; step(2); sda_in = 0; step(2);
    scl_in = 1; step(4); sda_in = 1; step(6);
  endtask

  task automatic pulse_hit();
    slave_hit = 1; step(1); slave_hit = 0;
  endtask

  task automatic clear_all();
    stop_clr = 1; err_clr = 1; step(1); stop_clr = 0; err_clr = 0; step(1);
  endtask

  initial begin
    step(3); rst_n = 1; step(1);
    chk("R1 busy", bus_busy, 0); chk("R1 stop_flag", stop_flag, 0); chk("R1 bus_err", bus_err, 0);
    enable = 1; step(2);

    // R2 R3 R7 R10: uninvolved full transfer
    do_start(); chk("R2 busy after START", bus_busy, 1);
    send_frame(8'hA5, 0); do_stop();
    chk("R3 busy after STOP", bus_busy, 0);
    chk("R7 stop_flag uninvolved", stop_flag, 0);
    chk("R10 no err at boundary", bus_err, 0);

    // R5 master transfer, then R11 clear
    own_master = 1; do_start(); send_frame(8'h3C, 0); do_stop();
    chk("R5 stop_flag as master", stop_flag, 1);
    stop_clr = 1; step(1); stop_clr = 0; step(1);
    chk("R11 stop_clr", stop_flag, 0);
    own_master = 0;

    // R6 addressed slave
    do_start(); addr_phase = 1; send_frame(8'h42, 0); addr_phase = 0; pulse_hit();
    send_frame(8'h11, 0); do_stop();
    chk("R6 stop_flag as slave", stop_flag, 1);
    clear_all();
    // R6 hit before repeated START does not count
    do_start(); pulse_hit(); send_frame(8'h42, 0); do_start();
    send_frame(8'h43, 1); do_stop();
    chk("R6 hit cleared by repeated START", stop_flag, 0);

    // R8 misplaced STOP while master
    own_master = 1; do_start(); send_bit(1); send_bit(0); send_bit(1); do_stop();
    chk("R8 misplaced STOP sets err", bus_err, 1);
    err_clr = 1; step(1); err_clr = 0; step(1);
    chk("R11 err_clr", bus_err, 0);
    clear_all();

    // R9 address phase suppresses
    do_start(); addr_phase = 1; send_bit(1); send_bit(1); do_stop(); addr_phase = 0;
    chk("R9 no err in address phase", bus_err, 0);
    clear_all();

    // R10 not involved
    own_master = 0; do_start(); send_bit(0); send_bit(1); send_bit(0); send_bit(0); do_stop();
    chk("R10 no err when uninvolved", bus_err, 0);

    // R11 set wins over a held clear
    own_master = 1; saw_stopf = 0; do_start(); send_frame(8'h00, 0);
    stop_clr = 1; do_stop(); stop_clr = 0;
    chk("R11 set wins over clear", saw_stopf, 1);
    clear_all();

    // R4 disable clears and blocks
    do_start(); send_bit(1); send_bit(0);
    scl_in = 0; step(2); sda_in = 1; step(2); scl_in = 1; step(4); sda_in = 0; step(6);
    chk("R8 misplaced START err", bus_err, 1);
    chk("R2 busy held", bus_busy, 1);
    enable = 0; step(2);
    chk("R4 busy cleared", bus_busy, 0); chk("R4 err cleared", bus_err, 0);
    scl_in = 0; step(2); sda_in = 1; step(2); scl_in = 1; do_start();
    chk("R4 START ignored", bus_busy, 0);
    do_stop();
    chk("R4 stop_flag held low", stop_flag, 0);
    enable = 1; step(4);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule